// File: doc/BRIEF.md
# Interrupt Destination Matcher and Dispatcher

This block takes one routed interrupt request (destination field, destination addressing mode, delivery mode, vector and trigger level) and decides which of a bank of local interrupt targets receive it. Every target holds a physical ID, an 8-bit logical ID and a 4-bit logical format code. The number of registered targets is held in a count register. Physical addressing selects a single target by ID. Logical addressing compares the destination against each target's logical ID under that target's flat or cluster model.

The chosen targets are then served by delivery mode. Fixed and external requests go to every matching target. Lowest-priority requests go to exactly one matching target, picked by a rotating pointer. All other delivery modes are dropped and flagged. An accepted request produces a one-cycle injection strobe one clock later. The strobe carries the target bitmask, the vector and a level-triggered flag. Target configuration arrives through a simple register-load port. Picking the request and the targets' own priority handling happen elsewhere.

Top module: `irq_dest_dispatch`

## Requirements
- R1: A load (`cfg_we`=1) writes the field chosen by `cfg_sel` of target `cfg_idx`. The encodings are 00 physical ID (`cfg_data`), 01 logical ID (`cfg_data`), 10 format code (`cfg_data[3:0]`) and 11 target count (ignores `cfg_idx`). A loaded value governs every request presented on a later cycle.
- R2: With `req_logical`=0 (physical addressing), only the lowest-indexed counted target whose physical ID equals `req_dest` is selected. At most one target is selected.
- R3: With `req_logical`=1 and `req_dest`=0, no target is selected.
- R4: A target with format code 4'hF (flat) matches a logical request when `req_dest` AND its logical ID is nonzero.
- R5: A target with format code 4'h0 (cluster) matches a logical request when its logical ID bits [7:4] equal `req_dest[7:4]` and the two [3:0] fields share a set bit.
- R6: A target with any other format code never matches a logical request.
- R7: Delivery mode 3'b000 (fixed) and 3'b111 (external) inject into every matching target.
- R8: Delivery mode 3'b001 (lowest priority) injects into exactly one matching target. The search starts at the target after the rotating pointer and wraps around. The pointer then moves to the chosen target. After reset the pointer sits at the last target, so the first search begins at target 0.
- R9: Delivery modes 010, 011, 100, 101 and 110 inject nothing and pulse `bad_mode` in the cycle after the request.
- R10: When no target matches, nothing is injected and the rotating pointer stays where it is.
- R11: An injection carries `req_vector` on `inj_vector`, and `inj_level` equals `req_level`.
- R12: Targets whose index is at or above the count register are never selected. The count resets to 0, and a loaded value above the number of targets saturates to that number.
- R13: The outputs are registered and appear in the cycle after `req_valid`, for one cycle only. When nothing is injected, `inj_valid`, `inj_mask`, `inj_vector` and `inj_level` are all 0. These outputs and `bad_mode` are 0 out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_sel | input | 2 | Field select for the load |
| cfg_idx | input | IDX_W | Target index for the load |
| cfg_data | input | 8 | Load value |
| req_valid | input | 1 | Request present this cycle |
| req_dest | input | 8 | Destination field |
| req_logical | input | 1 | 1 = logical addressing, 0 = physical |
| req_mode | input | 3 | Delivery mode |
| req_vector | input | VEC_W | Interrupt vector |
| req_level | input | 1 | 1 = level-triggered entry |
| inj_valid | output | 1 | Injection strobe |
| inj_mask | output | NUM_TGT | Targets receiving the injection |
| inj_vector | output | VEC_W | Vector to set in each target's request set |
| inj_level | output | 1 | Mark the vector as level-triggered |
| bad_mode | output | 1 | Unsupported delivery mode was dropped |

## Verification
The bench builds the block with 8 targets instead of 32. With so few targets, random 3-bit physical IDs often collide, which tests the first-match rule. The rotating pointer also wraps after only a few lowest-priority requests, and random count loads regularly push matching targets past the count limit. Format codes are drawn from flat, cluster and an invalid value, so one logical destination often hits targets of mixed models.

// File: rtl/irqdst_pkg.sv
package irqdst_pkg;

  localparam int DEST_W = 8;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'b000,
    DM_LOWPRI = 3'b001,
    DM_SMI    = 3'b010,
    DM_RSVD   = 3'b011,
    DM_NMI    = 3'b100,
    DM_INIT   = 3'b101,
    DM_START  = 3'b110,
    DM_EXT    = 3'b111
  } dmode_e;

  typedef enum logic [1:0] {
    CFG_PHYS  = 2'b00,
    CFG_LOGI  = 2'b01,
    CFG_FMT   = 2'b10,
    CFG_COUNT = 2'b11
  } cfg_sel_e;

  localparam logic [3:0] FMT_FLAT    = 4'hF;
  localparam logic [3:0] FMT_CLUSTER = 4'h0;

  // flat model: any shared bit between destination and logical ID
  function automatic logic flat_hit(input logic [DEST_W-1:0] dest,
                                    input logic [DEST_W-1:0] lid);
    return |(dest & lid);
  endfunction

  // cluster model: upper nibble is the cluster, lower nibble a member bitmap
  function automatic logic cluster_hit(input logic [DEST_W-1:0] dest,
                                       input logic [DEST_W-1:0] lid);
    return (dest[7:4] == lid[7:4]) && (|(dest[3:0] & lid[3:0]));
  endfunction

  function automatic logic logical_hit(input logic [3:0] fmt,
                                       input logic [DEST_W-1:0] dest,
                                       input logic [DEST_W-1:0] lid);
    case (fmt)
      FMT_FLAT:    return flat_hit(dest, lid);
      FMT_CLUSTER: return cluster_hit(dest, lid);
      default:     return 1'b0;
    endcase
  endfunction

  function automatic logic mode_supported(input logic [2:0] mode);
    return (mode == DM_FIXED) || (mode == DM_LOWPRI) || (mode == DM_EXT);
  endfunction

endpackage

// File: rtl/irqdst_tgt_regs.sv
module irqdst_tgt_regs
  import irqdst_pkg::*;
#(
  parameter int NUM_TGT = 32,
  parameter int IDX_W   = 5,
  parameter int CNT_W   = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [1:0]                      cfg_sel,
  input  logic [IDX_W-1:0]                cfg_idx,
  input  logic [DEST_W-1:0]               cfg_data,
  output logic [NUM_TGT-1:0][DEST_W-1:0]  phys_id,
  output logic [NUM_TGT-1:0][DEST_W-1:0]  log_id,
  output logic [NUM_TGT-1:0][3:0]         fmt,
  output logic [CNT_W-1:0]                tgt_count
);

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
    logic [DEST_W-1:0] phys_q;
    logic [DEST_W-1:0] lid_q;
    logic [3:0]        fmt_q;
    logic              sel_me;

    assign sel_me = cfg_we && (cfg_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        phys_q <= '0;
        lid_q  <= '0;
        fmt_q  <= FMT_FLAT;
      end else if (sel_me) begin
        case (cfg_sel)
          CFG_PHYS: phys_q <= cfg_data;
          CFG_LOGI: lid_q  <= cfg_data;
          CFG_FMT:  fmt_q  <= cfg_data[3:0];
          default:  ;
        endcase
      end
    end

    assign phys_id[g] = phys_q;
    assign log_id[g]  = lid_q;
    assign fmt[g]     = fmt_q;
  end

  logic count_load;
  assign count_load = cfg_we && (cfg_sel == CFG_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_count <= '0;
    end else if (count_load) begin
      if (cfg_data > DEST_W'(NUM_TGT)) tgt_count <= CNT_W'(NUM_TGT);
      else                             tgt_count <= CNT_W'(cfg_data);
    end
  end

endmodule

// File: rtl/irqdst_match.sv
module irqdst_match
  import irqdst_pkg::*;
#(
  parameter int NUM_TGT = 32,
  parameter int CNT_W   = 6
) (
  input  logic [NUM_TGT-1:0][DEST_W-1:0] phys_id,
  input  logic [NUM_TGT-1:0][DEST_W-1:0] log_id,
  input  logic [NUM_TGT-1:0][3:0]        fmt,
  input  logic [CNT_W-1:0]               tgt_count,
  input  logic [DEST_W-1:0]              dest,
  input  logic                           logical,
  output logic [NUM_TGT-1:0]             phys_mask,
  output logic [NUM_TGT-1:0]             log_mask,
  output logic [NUM_TGT-1:0]             match_mask
);

  logic [NUM_TGT-1:0] in_count;

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_cmp
    assign in_count[g] = (CNT_W'(g) < tgt_count);
    assign log_mask[g] = (dest != '0) && in_count[g] &&
                         logical_hit(fmt[g], dest, log_id[g]);
  end

  // physical: lowest index wins
  always_comb begin
    logic hit;
    hit       = 1'b0;
    phys_mask = '0;
    for (int i = 0; i < NUM_TGT; i++) begin
      if (!hit && in_count[i] && (phys_id[i] == dest)) begin
        phys_mask[i] = 1'b1;
        hit          = 1'b1;
      end
    end
  end

  assign match_mask = logical ? log_mask : phys_mask;

endmodule

// File: rtl/irqdst_rr_pick.sv
module irqdst_rr_pick #(
  parameter int NUM_TGT = 32,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_TGT-1:0] cand,
  input  logic               advance,
  output logic [NUM_TGT-1:0] pick_mask,
  output logic               pick_found,
  output logic [IDX_W-1:0]   rr_ptr
);

  logic [IDX_W-1:0] pick_idx;

  always_comb begin
    int j;
    pick_found = 1'b0;
    pick_idx   = '0;
    for (int k = 1; k <= NUM_TGT; k++) begin
      j = (int'(rr_ptr) + k) % NUM_TGT;
      if (!pick_found && cand[j]) begin
        pick_found = 1'b1;
        pick_idx   = IDX_W'(j);
      end
    end
  end

  assign pick_mask = pick_found ? (NUM_TGT'(1) << pick_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       rr_ptr <= IDX_W'(NUM_TGT - 1);
    else if (advance && pick_found)   rr_ptr <= pick_idx;
  end

endmodule

// File: rtl/irq_dest_dispatch.sv
module irq_dest_dispatch
  import irqdst_pkg::*;
#(
  parameter int NUM_TGT = 32,
  parameter int VEC_W   = 8,
  localparam int IDX_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1,
  localparam int CNT_W  = $clog2(NUM_TGT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [7:0]         cfg_data,
  input  logic               req_valid,
  input  logic [7:0]         req_dest,
  input  logic               req_logical,
  input  logic [2:0]         req_mode,
  input  logic [VEC_W-1:0]   req_vector,
  input  logic               req_level,
  output logic               inj_valid,
  output logic [NUM_TGT-1:0] inj_mask,
  output logic [VEC_W-1:0]   inj_vector,
  output logic               inj_level,
  output logic               bad_mode
);

  logic [NUM_TGT-1:0][DEST_W-1:0] phys_id;
  logic [NUM_TGT-1:0][DEST_W-1:0] log_id;
  logic [NUM_TGT-1:0][3:0]        fmt;
  logic [CNT_W-1:0]               tgt_count;
  logic [NUM_TGT-1:0]             phys_mask, log_mask, match_mask;
  logic [NUM_TGT-1:0]             pick_mask, deliver_mask;
  logic                           pick_found;
  logic [IDX_W-1:0]               rr_ptr;
  logic                           is_lowpri, is_sup, do_inject, lowpri_q;

  irqdst_tgt_regs #(.NUM_TGT(NUM_TGT), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .phys_id(phys_id),
    .log_id(log_id), .fmt(fmt), .tgt_count(tgt_count)
  );

  irqdst_match #(.NUM_TGT(NUM_TGT), .CNT_W(CNT_W)) u_match (
    .phys_id(phys_id), .log_id(log_id), .fmt(fmt), .tgt_count(tgt_count),
    .dest(req_dest), .logical(req_logical), .phys_mask(phys_mask),
    .log_mask(log_mask), .match_mask(match_mask)
  );

  assign is_lowpri = (req_mode == DM_LOWPRI);
  assign is_sup    = mode_supported(req_mode);

  irqdst_rr_pick #(.NUM_TGT(NUM_TGT), .IDX_W(IDX_W)) u_rr (
    .clk(clk), .rst_n(rst_n), .cand(match_mask),
    .advance(req_valid && is_lowpri), .pick_mask(pick_mask),
    .pick_found(pick_found), .rr_ptr(rr_ptr)
  );

  assign deliver_mask = is_lowpri ? pick_mask : match_mask;
  assign do_inject    = req_valid && is_sup && (deliver_mask != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inj_valid  <= 1'b0;
      inj_mask   <= '0;
      inj_vector <= '0;
      inj_level  <= 1'b0;
      bad_mode   <= 1'b0;
      lowpri_q   <= 1'b0;
    end else begin
      inj_valid  <= do_inject;
      inj_mask   <= do_inject ? deliver_mask : '0;
      inj_vector <= do_inject ? req_vector : '0;
      inj_level  <= do_inject && req_level;
      bad_mode   <= req_valid && !is_sup;
      lowpri_q   <= do_inject && is_lowpri;
    end
  end

  // R13: outputs are single-cycle responses to a request
  p_no_req_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!inj_valid && !bad_mode));

  // R2: physical addressing hits at most one target
  p_phys_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_logical) |=> $onehot0(inj_mask));

  // R3: logical destination zero reaches nobody
  p_logical_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_logical && req_dest == '0) |=> !inj_valid);

  // R8: lowest priority lands on one target, where the pointer now sits
  p_lowpri_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && lowpri_q) |-> ($onehot(inj_mask) && inj_mask[rr_ptr]));

  // R9: unsupported modes are flagged and never injected
  p_drop_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !is_sup) |=> (bad_mode && !inj_valid));

  // R11: level flag follows the request
  p_level_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_level) |=> !inj_level);

  // R12: nothing at or above the target count is selected
  p_count_limit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid |-> ((inj_mask >> $past(tgt_count)) == '0));

endmodule

// File: tb/tb_irq_dest_dispatch.sv
module tb_irq_dest_dispatch;

  localparam int NT = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [IW-1:0] cfg_idx = '0;
  logic [7:0]    cfg_data = '0;
  logic          req_valid = 1'b0;
  logic [7:0]    req_dest = '0;
  logic          req_logical = 1'b0;
  logic [2:0]    req_mode = '0;
  logic [7:0]    req_vector = '0;
  logic          req_level = 1'b0;
  logic          inj_valid;
  logic [NT-1:0] inj_mask;
  logic [7:0]    inj_vector;
  logic          inj_level;
  logic          bad_mode;

  always #5 clk = ~clk;

  irq_dest_dispatch #(.NUM_TGT(NT), .VEC_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .req_valid(req_valid),
    .req_dest(req_dest), .req_logical(req_logical), .req_mode(req_mode),
    .req_vector(req_vector), .req_level(req_level), .inj_valid(inj_valid),
    .inj_mask(inj_mask), .inj_vector(inj_vector), .inj_level(inj_level),
    .bad_mode(bad_mode)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference state
  logic [7:0] m_phys [NT];
  logic [7:0] m_lid  [NT];
  logic [3:0] m_fmt  [NT];
  int         m_cnt;
  int         m_rr;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NT-1:0] ref_match(input logic [7:0] d, input bit lg);
    logic [NT-1:0] r = '0;
    if (!lg) begin
      // walk down so the lowest index is written last
      for (int i = NT - 1; i >= 0; i--)
        if (i < m_cnt && m_phys[i] == d) r = NT'(1) << i;
    end else if (d != 8'h00) begin
      for (int i = 0; i < m_cnt; i++) begin
        if (m_fmt[i] == 4'hF)      r[i] = (d & m_lid[i]) != 8'h00;
        else if (m_fmt[i] == 4'h0) r[i] = (d[7:4] == m_lid[i][7:4]) &&
                                          ((d[3:0] & m_lid[i][3:0]) != 4'h0);
      end
    end
    return r;
  endfunction

  task automatic load(input logic [1:0] sel, input int idx, input logic [7:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = IW'(idx); cfg_data = val;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      2'b00: m_phys[idx] = val;
      2'b01: m_lid[idx]  = val;
      2'b10: m_fmt[idx]  = val[3:0];
      default: m_cnt = (int'(val) > NT) ? NT : int'(val);
    endcase
  endtask

  task automatic send(input string tag, input logic [7:0] d, input bit lg,
                      input logic [2:0] md, input logic [7:0] vec, input bit lvl);
    logic [NT-1:0] mm, em;
    bit sup, ev;
    mm  = ref_match(d, lg);
    sup = (md == 3'b000) || (md == 3'b001) || (md == 3'b111);
    em  = '0;
    if (md == 3'b001) begin
      for (int k = 1; k <= NT; k++) begin
        int j;
        j = (m_rr + k) % NT;
        if (mm[j]) begin em = NT'(1) << j; m_rr = j; break; end
      end
    end else if (sup) begin
      em = mm;
    end
    ev = sup && (em != '0);
    @(negedge clk);
    req_valid = 1'b1; req_dest = d; req_logical = lg; req_mode = md;
    req_vector = vec; req_level = lvl;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " inj_valid"}, 64'(inj_valid), 64'(ev));
    chk({tag, " inj_mask"},  64'(inj_mask),  64'(em));
    chk({tag, " inj_vector"}, 64'(inj_vector), ev ? 64'(vec) : 64'h0);
    chk({tag, " inj_level"}, 64'(inj_level), 64'(ev && lvl));
    chk({tag, " bad_mode"},  64'(bad_mode),  64'(!sup));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < NT; i++) begin
      m_phys[i] = 8'h00; m_lid[i] = 8'h00; m_fmt[i] = 4'hF;
    end
    m_cnt = 0;
    m_rr  = NT - 1;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 reset inj_valid", 64'(inj_valid), 64'h0);
    chk("R13 reset inj_mask", 64'(inj_mask), 64'h0);
    chk("R13 reset bad_mode", 64'(bad_mode), 64'h0);
    rst_n = 1'b1;
    // R12: count 0 after reset; all ids are 0, still nothing selected
    send("R12", 8'h00, 1'b0, 3'b000, 8'h20, 1'b0);

    load(2'b11, 0, 8'd4);
    load(2'b00, 0, 8'h05); load(2'b00, 1, 8'h09);
    load(2'b00, 2, 8'h05); load(2'b00, 3, 8'h07);
    load(2'b01, 0, 8'h01); load(2'b01, 1, 8'h02);
    load(2'b01, 2, 8'h31); load(2'b01, 3, 8'h30);
    load(2'b10, 2, 8'h00); load(2'b10, 3, 8'h00);

    send("R2", 8'h05, 1'b0, 3'b000, 8'h30, 1'b0);
    load(2'b00, 0, 8'h06);
    send("R1", 8'h05, 1'b0, 3'b000, 8'h31, 1'b0);
    load(2'b00, 6, 8'h42);
    send("R12", 8'h42, 1'b0, 3'b000, 8'h32, 1'b0);
    load(2'b11, 0, 8'd200);
    send("R12", 8'h42, 1'b0, 3'b000, 8'h33, 1'b0);
    send("R3", 8'h00, 1'b1, 3'b000, 8'h34, 1'b0);
    send("R4", 8'h03, 1'b1, 3'b000, 8'h35, 1'b0);
    send("R5", 8'h31, 1'b1, 3'b000, 8'h36, 1'b0);
    load(2'b10, 3, 8'h05); load(2'b01, 3, 8'hFF);
    send("R6", 8'h3F, 1'b1, 3'b000, 8'h37, 1'b0);
    send("R7", 8'h03, 1'b1, 3'b111, 8'h38, 1'b0);
    send("R8", 8'h03, 1'b1, 3'b001, 8'h39, 1'b0);
    send("R8", 8'h03, 1'b1, 3'b001, 8'h3A, 1'b0);
    send("R8", 8'h03, 1'b1, 3'b001, 8'h3B, 1'b0);
    send("R10", 8'hEE, 1'b0, 3'b001, 8'h3C, 1'b0);
    send("R8", 8'h03, 1'b1, 3'b001, 8'h3D, 1'b0);
    for (int m = 2; m <= 6; m++)
      send("R9", 8'h03, 1'b1, 3'(m), 8'h3E, 1'b1);
    send("R10", 8'hEE, 1'b0, 3'b000, 8'h3F, 1'b1);
    send("R11", 8'h03, 1'b1, 3'b000, 8'hA5, 1'b1);
    @(negedge clk);
    chk("R13 pulse ends", 64'(inj_valid), 64'h0);

    for (int n = 0; n < 500; n++) begin
      if ($urandom_range(0, 3) == 0) begin
        int sel, idx;
        logic [7:0] v;
        sel = $urandom_range(0, 3);
        idx = $urandom_range(0, NT - 1);
        case (sel)
          0: v = 8'($urandom_range(0, 7));
          1: v = 8'($urandom);
          2: begin
               int f;
               f = $urandom_range(0, 2);
               v = (f == 0) ? 8'h0F : ((f == 1) ? 8'h00 : 8'h03);
             end
          default: v = 8'($urandom_range(0, NT + 1));
        endcase
        load(2'(sel), idx, v);
      end else begin
        logic [7:0] d;
        logic [2:0] md;
        bit lg;
        lg = $urandom_range(0, 1) == 1;
        d  = lg ? 8'($urandom) : 8'($urandom_range(0, 8));
        md = ($urandom_range(0, 3) != 0) ? 3'($urandom_range(0, 1)) : 3'($urandom);
        send(md == 3'b001 ? "R8" : (md == 3'b000 || md == 3'b111) ? "R7" : "R9",
             d, lg, md, 8'($urandom), $urandom_range(0, 1) == 1);
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule